// File: doc/BRIEF.md
# Size-Prefixed Instruction Fetch Sequencer

This block walks a byte-wide program memory one byte per clock. It reads a one-byte opcode, then reads as many operand bytes as that opcode needs. It keeps two persistent widths, one for data and one for addresses. One-shot prefix opcodes can override either width for exactly one following instruction. Absolute jumps and relative jumps, each with plain, zero-taken and nonzero-taken forms, are resolved inside the block. The instruction pointer always stays inside the memory.

Every opcode that the sequencer does not own is passed to an external execute stage, together with the effective widths for that instruction. The sequencer holds it there until the stage strobes done. The zero flag comes from outside and is only sampled when a conditional jump resolves.

Top module: `isize_fetch_seq`

## Requirements
- R1: While reset is held, `ip_o` is 0, `halted` and `exec_valid` are low, and `exec_dwidth` and `exec_awidth` both show width code 2 (16-bit). Width codes are 1 = 8-bit, 2 = 16-bit, 3 = 32-bit and 4 = 64-bit.
- R2: An opcode outside the sequencer's own set (for example 2 or 39..43) raises `exec_valid` with that byte on `exec_opcode`. At that point `ip_o` points one past the opcode byte. All of these stay steady until a cycle with `exec_done` high, and the next fetch follows that cycle.
- R3: Prefix opcodes 29..32 set a pending data width of 8/16/32/64, and 44..47 set a pending address width of 8/16/32/64. The next non-prefix instruction runs with the pending width, and afterwards the earlier width returns. A later prefix of the same kind replaces an earlier one. Prefixes of the two kinds combine.
- R4: Opcode 33 (data) and opcode 34 (address) read one operand byte holding a width code and make it the persistent width. A byte outside 1..4 leaves the width unchanged.
- R5: When a set-width opcode runs under a prefix of the same kind, the restore step at the end of that instruction undoes the new setting, and the width held before the prefix comes back.
- R6: Jump operands are as many bytes as the effective address width (1, 2, 4 or 8), least significant byte first. `opnd_value` shows the raw operand of the most recent operand-bearing instruction, zero-extended.
- R7: Opcode 4 jumps to the zero-extended operand. Opcode 5 jumps only when `zero_flag` is 1, and opcode 6 only when it is 0. An untaken jump still consumes its operand.
- R8: Opcode 7 adds the operand, sign-extended from the address width, to the address just past the operand. Opcode 8 does this only when `zero_flag` is 1, and opcode 9 only when it is 0. An untaken form still consumes the operand.
- R9: After every instruction the pointer is reduced modulo `MEM_BYTES`. Absolute targets above the memory and relative targets below zero therefore wrap.
- R10: Opcode 1 sets `halted`. After that nothing more is fetched or handed off, and `ip_o` stays one past the halt byte until reset. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW | Program memory byte address |
| mem_rdata | input | 8 | Program memory byte, read combinationally at `mem_addr` |
| zero_flag | input | 1 | Zero flag used by conditional jumps |
| exec_valid | output | 1 | An opcode is waiting for the execute stage |
| exec_opcode | output | 8 | Opcode handed to the execute stage |
| exec_dwidth | output | 3 | Data width code in force |
| exec_awidth | output | 3 | Address width code in force |
| exec_done | input | 1 | Execute stage has finished the handed-off opcode |
| opnd_value | output | 64 | Raw operand of the last operand-bearing instruction |
| ip_o | output | AW | Instruction pointer |
| halted | output | 1 | Halt opcode reached |

## Verification
The assertions assume that the execute stage raises `exec_done` only while `exec_valid` is high. They also assume that `mem_rdata` settles within the cycle for whatever `mem_addr` shows. The bench models the memory as a combinational array. Its execute model pulses `exec_done` for a single cycle only after it has seen `exec_valid` at a falling edge, and it changes `zero_flag` only while a handoff is being acknowledged. That way the flag never moves in the middle of a conditional jump.

// File: rtl/isf_pkg.sv
package isf_pkg;

    typedef enum logic [1:0] {
        S_FETCH = 2'd0,
        S_OPND  = 2'd1,
        S_EXEC  = 2'd2,
        S_HALT  = 2'd3
    } seq_state_e;

    localparam int OPND_BYTES = 8;

    localparam logic [2:0] W_NONE = 3'd0;
    localparam logic [2:0] W_8    = 3'd1;
    localparam logic [2:0] W_16   = 3'd2;
    localparam logic [2:0] W_32   = 3'd3;
    localparam logic [2:0] W_64   = 3'd4;

    localparam logic [7:0] OP_NOP    = 8'd0;
    localparam logic [7:0] OP_HALT   = 8'd1;
    localparam logic [7:0] OP_JP     = 8'd4;
    localparam logic [7:0] OP_JZ     = 8'd5;
    localparam logic [7:0] OP_JNZ    = 8'd6;
    localparam logic [7:0] OP_JR     = 8'd7;
    localparam logic [7:0] OP_JRZ    = 8'd8;
    localparam logic [7:0] OP_JRNZ   = 8'd9;
    localparam logic [7:0] OP_DPRE8  = 8'd29;
    localparam logic [7:0] OP_DPRE64 = 8'd32;
    localparam logic [7:0] OP_SETD   = 8'd33;
    localparam logic [7:0] OP_SETA   = 8'd34;
    localparam logic [7:0] OP_APRE8  = 8'd44;
    localparam logic [7:0] OP_APRE64 = 8'd47;

    function automatic logic [3:0] width_bytes(input logic [2:0] w);
        case (w)
            W_8:     return 4'd1;
            W_16:    return 4'd2;
            W_32:    return 4'd4;
            W_64:    return 4'd8;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [63:0] sign_ext(input logic [63:0] v, input logic [2:0] w);
        case (w)
            W_8:     return {{56{v[7]}}, v[7:0]};
            W_16:    return {{48{v[15]}}, v[15:0]};
            W_32:    return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic width_code_ok(input logic [7:0] b);
        return (b >= 8'd1) && (b <= 8'd4);
    endfunction

endpackage

// File: rtl/isf_width_track.sv
module isf_width_track
    import isf_pkg::*;
#(
    parameter logic [2:0] RESET_W = W_16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pend_wr,
    input  logic [2:0] pend_code,
    input  logic       apply,
    input  logic       set_wr,
    input  logic [2:0] set_code,
    input  logic       finish,
    output logic [2:0] eff_w,
    output logic [2:0] cur_w
);

    typedef struct packed {
        logic [2:0] cur;
        logic [2:0] saved;
        logic [2:0] pend;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (pend_wr) begin
            trk_d.pend = pend_code;
        end
        if (apply && (trk_q.pend != W_NONE)) begin
            trk_d.saved = trk_q.cur;
            trk_d.cur   = trk_q.pend;
            trk_d.pend  = W_NONE;
        end
        if (set_wr) begin
            trk_d.cur = set_code;
        end
        if (finish && (trk_d.saved != W_NONE)) begin
            trk_d.cur   = trk_d.saved;
            trk_d.saved = W_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{cur: RESET_W, saved: W_NONE, pend: W_NONE};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign eff_w = (apply && (trk_q.pend != W_NONE)) ? trk_q.pend : trk_q.cur;
    assign cur_w = trk_q.cur;

    // R4
    width_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.cur != W_NONE) && (trk_q.cur <= W_64));

endmodule

// File: rtl/isf_opnd_asm.sv
module isf_opnd_asm
    import isf_pkg::*;
#(
    parameter int NB = OPND_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_wr,
    input  logic [2:0]        byte_idx,
    input  logic [7:0]        byte_in,
    output logic [8*NB-1:0]   value_next,
    output logic [8*NB-1:0]   value_q
);

    logic [7:0] lane_d [NB];
    logic [7:0] lane_q [NB];

    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_comb begin
            if (byte_wr && (byte_idx == 3'(i))) begin
                lane_d[i] = byte_in;
            end else if (byte_wr && (byte_idx == 3'd0)) begin
                lane_d[i] = 8'h00;
            end else begin
                lane_d[i] = lane_q[i];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[i] <= 8'h00;
            end else begin
                lane_q[i] <= lane_d[i];
            end
        end

        assign value_next[8*i +: 8] = lane_d[i];
        assign value_q[8*i +: 8]    = lane_q[i];
    end

    // R6
    low_byte_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && (byte_idx != 3'd0)) |=> (value_q[7:0] == $past(value_q[7:0])));

endmodule

// File: rtl/isize_fetch_seq.sv
module isize_fetch_seq
    import isf_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int AW        = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    input  logic          zero_flag,
    output logic          exec_valid,
    output logic [7:0]    exec_opcode,
    output logic [2:0]    exec_dwidth,
    output logic [2:0]    exec_awidth,
    input  logic          exec_done,
    output logic [63:0]   opnd_value,
    output logic [AW-1:0] ip_o,
    output logic          halted
);

    localparam int CNT_W = $clog2(OPND_BYTES);

    typedef struct packed {
        seq_state_e      st;
        logic [AW-1:0]   ip;
        logic [7:0]      opc;
        logic [3:0]      nbytes;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic       d_pend_wr, a_pend_wr, apply, finish;
    logic       d_set_wr, a_set_wr, byte_wr;
    logic [2:0] pend_code, set_code;
    logic [2:0] d_eff, d_cur, a_eff, a_cur;
    logic [63:0] opnd_next, opnd_q;
    logic [AW-1:0] ip_inc, rel_target;
    logic [63:0]   rel_sum;
    logic          last_byte;

    isf_width_track #(.RESET_W(W_16)) u_dwidth (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_wr   (d_pend_wr),
        .pend_code (pend_code),
        .apply     (apply),
        .set_wr    (d_set_wr),
        .set_code  (set_code),
        .finish    (finish),
        .eff_w     (d_eff),
        .cur_w     (d_cur)
    );

    isf_width_track #(.RESET_W(W_16)) u_awidth (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_wr   (a_pend_wr),
        .pend_code (pend_code),
        .apply     (apply),
        .set_wr    (a_set_wr),
        .set_code  (set_code),
        .finish    (finish),
        .eff_w     (a_eff),
        .cur_w     (a_cur)
    );

    isf_opnd_asm #(.NB(OPND_BYTES)) u_opnd (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_wr    (byte_wr),
        .byte_idx   (3'(seq_q.cnt)),
        .byte_in    (mem_rdata),
        .value_next (opnd_next),
        .value_q    (opnd_q)
    );

    assign ip_inc     = seq_q.ip + 1'b1;
    assign rel_sum    = 64'(ip_inc) + sign_ext(opnd_next, a_cur);
    assign rel_target = rel_sum[AW-1:0];
    assign last_byte  = ((4'(seq_q.cnt) + 4'd1) == seq_q.nbytes);

    always_comb begin
        seq_d      = seq_q;
        d_pend_wr  = 1'b0;
        a_pend_wr  = 1'b0;
        pend_code  = W_NONE;
        apply      = 1'b0;
        finish     = 1'b0;
        d_set_wr   = 1'b0;
        a_set_wr   = 1'b0;
        set_code   = W_NONE;
        byte_wr    = 1'b0;
        exec_valid = 1'b0;

        case (seq_q.st)
            S_FETCH: begin
                seq_d.ip  = ip_inc;
                seq_d.opc = mem_rdata;
                seq_d.cnt = '0;
                if ((mem_rdata >= OP_DPRE8) && (mem_rdata <= OP_DPRE64)) begin
                    d_pend_wr = 1'b1;
                    pend_code = 3'(mem_rdata - OP_DPRE8) + 3'd1;
                end else if ((mem_rdata >= OP_APRE8) && (mem_rdata <= OP_APRE64)) begin
                    a_pend_wr = 1'b1;
                    pend_code = 3'(mem_rdata - OP_APRE8) + 3'd1;
                end else begin
                    apply = 1'b1;
                    case (mem_rdata)
                        OP_NOP: begin
                            finish = 1'b1;
                        end
                        OP_HALT: begin
                            finish   = 1'b1;
                            seq_d.st = S_HALT;
                        end
                        OP_JP, OP_JZ, OP_JNZ, OP_JR, OP_JRZ, OP_JRNZ: begin
                            seq_d.st     = S_OPND;
                            seq_d.nbytes = width_bytes(a_eff);
                        end
                        OP_SETD, OP_SETA: begin
                            seq_d.st     = S_OPND;
                            seq_d.nbytes = 4'd1;
                        end
                        default: begin
                            seq_d.st = S_EXEC;
                        end
                    endcase
                end
            end

            S_OPND: begin
                byte_wr   = 1'b1;
                seq_d.ip  = ip_inc;
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (last_byte) begin
                    finish   = 1'b1;
                    seq_d.st = S_FETCH;
                    set_code = mem_rdata[2:0];
                    case (seq_q.opc)
                        OP_SETD: d_set_wr = width_code_ok(mem_rdata);
                        OP_SETA: a_set_wr = width_code_ok(mem_rdata);
                        OP_JP:   seq_d.ip = opnd_next[AW-1:0];
                        OP_JZ:   if (zero_flag)  seq_d.ip = opnd_next[AW-1:0];
                        OP_JNZ:  if (!zero_flag) seq_d.ip = opnd_next[AW-1:0];
                        OP_JR:   seq_d.ip = rel_target;
                        OP_JRZ:  if (zero_flag)  seq_d.ip = rel_target;
                        OP_JRNZ: if (!zero_flag) seq_d.ip = rel_target;
                        default: ;
                    endcase
                end
            end

            S_EXEC: begin
                exec_valid = 1'b1;
                if (exec_done) begin
                    finish   = 1'b1;
                    seq_d.st = S_FETCH;
                end
            end

            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: S_FETCH, ip: '0, opc: OP_NOP, nbytes: 4'd1, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_addr    = seq_q.ip;
    assign ip_o        = seq_q.ip;
    assign exec_opcode = seq_q.opc;
    assign exec_dwidth = d_cur;
    assign exec_awidth = a_cur;
    assign opnd_value  = opnd_q;
    assign halted      = (seq_q.st == S_HALT);

    // R2
    exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !exec_done) |=> (exec_valid && $stable(exec_opcode) && $stable(ip_o)));

    // R3
    exec_width_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !exec_done) |=> ($stable(exec_dwidth) && $stable(exec_awidth)));

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(ip_o)));

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !exec_valid);

endmodule

// File: tb/isize_fetch_seq_bench.sv
module isize_fetch_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MEMB       = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_rdata;
    logic        zero_flag = 1'b0;
    logic        exec_valid;
    logic [7:0]  exec_opcode;
    logic [2:0]  exec_dwidth;
    logic [2:0]  exec_awidth;
    logic        exec_done = 1'b0;
    logic [63:0] opnd_value;
    logic [7:0]  ip_o;
    logic        halted;

    logic [7:0] mem [MEMB];

    int checks = 0;
    int failures = 0;
    bit done_r = 1'b0;

    typedef struct {
        logic [7:0]  op;
        logic [2:0]  dw;
        logic [2:0]  aw;
        logic [63:0] opnd;
        logic [7:0]  ip;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    isize_fetch_seq #(.MEM_BYTES(MEMB)) u_isize_fetch_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .zero_flag   (zero_flag),
        .exec_valid  (exec_valid),
        .exec_opcode (exec_opcode),
        .exec_dwidth (exec_dwidth),
        .exec_awidth (exec_awidth),
        .exec_done   (exec_done),
        .opnd_value  (opnd_value),
        .ip_o        (ip_o),
        .halted      (halted)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input logic [7:0] op, input logic [2:0] dw, input logic [2:0] aw,
                               input logic [63:0] opnd, input logic [7:0] ip, input string tag);
        item_t it;
        it.op = op; it.dw = dw; it.aw = aw; it.opnd = opnd; it.ip = ip; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic put(input int addr, input logic [7:0] b);
        mem[addr] = b;
    endtask

    // Execute-stage model and scoreboard monitor; opcode 40 sets Z, 41 clears Z
    initial begin
        forever begin
            @(negedge clk);
            if (done_r) begin
                exec_done = 1'b0;
                done_r    = 1'b0;
            end else if (rst_n && exec_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R2 unexpected handoff actual=%h expected=none", exec_opcode);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check({it.tag, " opcode"}, 64'(exec_opcode), 64'(it.op));
                    check({it.tag, " dwidth"}, 64'(exec_dwidth), 64'(it.dw));
                    check({it.tag, " awidth"}, 64'(exec_awidth), 64'(it.aw));
                    check({it.tag, " operand"}, opnd_value, it.opnd);
                    check({it.tag, " ip"}, 64'(ip_o), 64'(it.ip));
                end
                if (exec_opcode == 8'd40) zero_flag = 1'b1;
                if (exec_opcode == 8'd41) zero_flag = 1'b0;
                exec_done = 1'b1;
                done_r    = 1'b1;
            end
        end
    end

    task automatic run_program(input string name, input logic [7:0] halt_ip);
        int n;
        rst_n = 1'b0;
        zero_flag = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset ip", 64'(ip_o), 64'd0);
        check("R1 reset halted", 64'(halted), 64'd0);
        check("R1 reset exec_valid", 64'(exec_valid), 64'd0);
        check("R1 reset dwidth", 64'(exec_dwidth), 64'd2);
        check("R1 reset awidth", 64'(exec_awidth), 64'd2);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!halted) begin
            checks++;
            failures++;
            $display("FAIL R10 %s watchdog actual=running expected=halted", name);
        end
        repeat (5) @(negedge clk);
        // R10
        check({"R10 ", name, " halted sticky"}, 64'(halted), 64'd1);
        check({"R10 ", name, " ip after halt"}, 64'(ip_o), 64'(halt_ip));
        check({"R10 ", name, " no handoff after halt"}, 64'(exec_valid), 64'd0);
        check({"R2 ", name, " all handoffs seen"}, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Program A: widths, prefixes, set-width opcodes
        for (int i = 0; i < MEMB; i++) mem[i] = 8'd1;
        put(0, 8'd2);
        put(1, 8'd29); put(2, 8'd2);
        put(3, 8'd2);
        put(4, 8'd46); put(5, 8'd32); put(6, 8'd2);
        put(7, 8'd29); put(8, 8'd31); put(9, 8'd2);
        put(10, 8'd33); put(11, 8'd3); put(12, 8'd2);
        put(13, 8'd29); put(14, 8'd33); put(15, 8'd4); put(16, 8'd2);
        put(17, 8'd33); put(18, 8'd7); put(19, 8'd2);
        put(20, 8'd34); put(21, 8'd1); put(22, 8'd2);
        put(23, 8'd1);
        expect_item(8'd2, 3'd2, 3'd2, 64'd0, 8'd1,  "R2 plain handoff");
        expect_item(8'd2, 3'd1, 3'd2, 64'd0, 8'd3,  "R3 data prefix 8");
        expect_item(8'd2, 3'd2, 3'd2, 64'd0, 8'd4,  "R3 data width restored");
        expect_item(8'd2, 3'd4, 3'd3, 64'd0, 8'd7,  "R3 prefixes combine");
        expect_item(8'd2, 3'd3, 3'd2, 64'd0, 8'd10, "R3 later prefix wins");
        expect_item(8'd2, 3'd3, 3'd2, 64'd3, 8'd13, "R4 set data width 32");
        expect_item(8'd2, 3'd3, 3'd2, 64'd4, 8'd17, "R5 prefixed set undone");
        expect_item(8'd2, 3'd3, 3'd2, 64'd7, 8'd20, "R4 bad width ignored");
        expect_item(8'd2, 3'd3, 3'd1, 64'd1, 8'd23, "R4 set address width 8");
        run_program("progA", 8'd24);

        // Program B: absolute and relative jumps, wrap, conditionals
        for (int i = 0; i < MEMB; i++) mem[i] = 8'd1;
        put(0, 8'd4); put(1, 8'h08); put(2, 8'h12);
        put(8, 8'd40);
        put(9, 8'd5); put(10, 8'd15); put(11, 8'd0);
        put(15, 8'd6); put(16, 8'h50); put(17, 8'h00);
        put(18, 8'd41);
        put(19, 8'd5); put(20, 8'h60); put(21, 8'h00);
        put(22, 8'd44); put(23, 8'd7); put(24, 8'h04);
        put(29, 8'd42);
        put(30, 8'd44); put(31, 8'd9); put(32, 8'hC0);
        put(225, 8'd43);
        put(226, 8'd8); put(227, 8'h10); put(228, 8'h00);
        put(229, 8'd47); put(230, 8'd7); put(231, 8'h75);
        for (int i = 232; i < 239; i++) put(i, 8'hFF);
        put(100, 8'd39);
        put(101, 8'd1);
        expect_item(8'd40, 3'd2, 3'd2, 64'h1208, 8'd9,   "R9 absolute jump wraps");
        expect_item(8'd41, 3'd2, 3'd2, 64'h0050, 8'd19,  "R7 jz taken then jnz skipped");
        expect_item(8'd42, 3'd2, 3'd2, 64'h04, 8'd30,    "R8 relative 8-bit forward");
        expect_item(8'd43, 3'd2, 3'd2, 64'hC0, 8'd226,   "R8 relative negative wraps");
        expect_item(8'd39, 3'd2, 3'd2, 64'hFFFF_FFFF_FFFF_FF75, 8'd101, "R6 eight byte offset");
        run_program("progB", 8'd102);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule